// File: doc/BRIEF.md
# Programmable-Logic Self-Test Sequencer

This block drives a self-test of lookup-table logic and routing wires and then runs one launch-capture timing probe. A single controller walks through a fixed order: a setup cycle, a lookup-table pass, a wire sweep and a delay probe. A stimulus decoder turns the controller state into write strobes, addresses, data, wire vectors and a launch level. A response analyser compares the outputs of two identical units under test and also checks the capture level of the timed path. It latches the first failure it sees.

Both units under test take the same stimulus. A fault in either unit shows up as a disagreement between their responses. The lookup-table pass writes an alternating pattern, reads it back, then writes and reads the inverse, so each cell is read once as 0 and once as 1. The wire sweep drives an all-zero vector and then moves a single one across every wire. A two-bit run-mode input can limit a session to one phase. An abort input stops a session at once.

Top module: `lbist_sequencer`

## Requirements
- R1: A start seen while idle begins a session. `busy_o` is high from the next cycle until `done_o` rises. With run mode 00, `done_o` rises 6 + 4·2^AW + NW cycles after the start edge; with modes 01, 10 and 11 it rises 2 + 4·2^AW, 3 + NW and 5 cycles after it.
- R2: Run mode 00 runs setup, then the lookup-table phase, then the wire phase, then the delay phase. Mode 01 runs only the lookup-table phase, 10 only the wire phase and 11 only the delay phase. A fault in a phase that is not run is not reported.
- R3: The lookup-table phase writes addresses 0 up to 2^AW−1 in ascending order with data equal to address bit 0, reads them all in the same order, then writes them with data equal to the inverse of address bit 0 and reads them all again. `lut_we_o` is high only during the write cycles.
- R4: During every lookup-table read cycle and every wire step, any bit that differs between `resp_a_i` and `resp_b_i` is a fault. `route_wire_o` is high during the wire steps and low otherwise, and it tells the units whether to present their wire outputs or their lookup-table read bit (bit 0, other bits 0).
- R5: Wire step 0 drives all zeros on `wire_vec_o`. Step k (1..NW) drives a single one at bit k−1. Outside the wire phase the vector is zero.
- R6: The delay phase spends one cycle with `launch_o` low, in which `capture_i` must be 0. `launch_o` is then high for two cycles. In the second of these cycles, one clock period after the launch edge, `capture_i` must be 1; otherwise the path is faulty.
- R7: `fail_o` stays set until the next accepted start clears it. `fclass_o` reports the phase of the fault: 01 lookup table, 10 wires, 11 delay, 00 no fault.
- R8: `diag_o` holds the failing lookup-table address, or the failing wire step number (0 for the all-zero vector), or for the delay phase 0 (capture high before launch) or 1 (capture late).
- R9: Only the first fault of a session is recorded. Later faults change neither `fclass_o` nor `diag_o`.
- R10: `done_o` rises one cycle after the last evaluation of the session and stays high until the next accepted start.
- R11: `abort_i` during a session returns the block to idle on the next edge. `busy_o` and `done_o` are then low and all stimulus is idle.
- R12: A start while a session is running is ignored and does not change its timing.
- R13: After reset, `busy_o`, `done_o`, `fail_o`, `fclass_o`, `lut_we_o`, `route_wire_o` and `launch_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a session (sampled while idle) |
| abort_i | input | 1 | Stop the running session |
| mode_i | input | 2 | Run-mode select, captured at start |
| lut_we_o | output | 1 | Lookup-table write strobe |
| lut_addr_o | output | AW | Lookup-table cell address |
| lut_wdata_o | output | 1 | Lookup-table write data |
| route_wire_o | output | 1 | Units present wire outputs when high |
| wire_vec_o | output | NW | Wire test vector |
| resp_a_i | input | NW | Response of unit A |
| resp_b_i | input | NW | Response of unit B |
| launch_o | output | 1 | Launch level of the timed path |
| capture_i | input | 1 | Capture flop of the timed path |
| busy_o | output | 1 | Session running |
| done_o | output | 1 | Session completed |
| fail_o | output | 1 | Sticky fault flag |
| fclass_o | output | 2 | Phase of the first fault |
| diag_o | output | CW | Address, step or delay code of the first fault |

## Verification
The lookup-table phase is tried with stuck-at-1 and stuck-at-0 cells at even and odd addresses in either unit. This tells apart faults caught by the first pass from faults caught by the inverse pass, and two faults in one run show that the earliest read address is the one kept. The wire sweep is tried with a bridge between two wires and with a wire stuck at 1. This separates detection on a walking step from detection on the all-zero vector. The delay probe is tried with a path one cycle slow and with a capture stuck high, which give the two delay codes. Mode selection, abort, a repeated start and a full run carrying faults in two phases show sequencing, masking and first-fault priority.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LWR,
    ST_LRD,
    ST_WIRE,
    ST_DLO,
    ST_DHI,
    ST_DEVAL,
    ST_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    RUN_ALL   = 2'b00,
    RUN_LUT   = 2'b01,
    RUN_WIRE  = 2'b10,
    RUN_DELAY = 2'b11
  } run_mode_e;

  localparam logic [1:0] FC_NONE  = 2'b00;
  localparam logic [1:0] FC_LUT   = 2'b01;
  localparam logic [1:0] FC_WIRE  = 2'b10;
  localparam logic [1:0] FC_DELAY = 2'b11;

endpackage

// File: rtl/lbist_rst_sync.sv
module lbist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sync_n = pipe_q[1];

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int AW = 4,
  parameter int NW = 8,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic [1:0]      mode_i,
  output seq_state_e      state_o,
  output logic [CW-1:0]   cnt_o,
  output logic            pass_o,
  output logic            clr_o,
  output logic            busy_o,
  output logic            done_o
);

  localparam int unsigned   DEPTH     = 1 << AW;
  localparam logic [CW-1:0] LAST_CELL = CW'(DEPTH - 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(NW);

  seq_state_e    state_q, state_d;
  run_mode_e     mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pass_q, pass_d;
  logic          done_q, done_d;
  logic          accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    pass_d  = pass_q;
    done_d  = done_q;
    if (state_q == ST_IDLE) begin
      if (accept) begin
        state_d = ST_SETUP;
        mode_d  = run_mode_e'(mode_i);
        cnt_d   = '0;
        pass_d  = 1'b0;
        done_d  = 1'b0;
      end
    end else if (abort_i) begin
      state_d = ST_IDLE;
      done_d  = 1'b0;
    end else begin
      case (state_q)
        ST_SETUP: begin
          cnt_d  = '0;
          pass_d = 1'b0;
          case (mode_q)
            RUN_ALL, RUN_LUT: state_d = ST_LWR;
            RUN_WIRE:         state_d = ST_WIRE;
            default:          state_d = ST_DLO;
          endcase
        end
        ST_LWR: begin
          if (cnt_q == LAST_CELL) begin
            state_d = ST_LRD;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_LRD: begin
          if (cnt_q != LAST_CELL) begin
            cnt_d = cnt_q + 1'b1;
          end else if (!pass_q) begin
            state_d = ST_LWR;
            pass_d  = 1'b1;
            cnt_d   = '0;
          end else begin
            cnt_d   = '0;
            state_d = (mode_q == RUN_LUT) ? ST_FIN : ST_WIRE;
          end
        end
        ST_WIRE: begin
          if (cnt_q == LAST_STEP) begin
            cnt_d   = '0;
            state_d = (mode_q == RUN_WIRE) ? ST_FIN : ST_DLO;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DLO:   state_d = ST_DHI;
        ST_DHI:   state_d = ST_DEVAL;
        ST_DEVAL: state_d = ST_FIN;
        ST_FIN: begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= RUN_ALL;
      cnt_q   <= '0;
      pass_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      pass_q  <= pass_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign pass_o  = pass_q;
  assign clr_o   = accept;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  // R2: a full run moves from the inverse read pass to the wire sweep
  assert_lut_then_wire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LRD && pass_q && cnt_q == LAST_CELL && mode_q == RUN_ALL && !abort_i)
      |=> (state_q == ST_WIRE));

  // R10: done follows the delay evaluation by one cycle
  assert_done_after_eval_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEVAL && !abort_i) |=> ##1 done_q);

  // R11: abort leaves nothing running and nothing reported as done
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && abort_i) |=> (!busy_o && !done_q));

  // R12: a start during a session does not restart it
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LWR && start_i && !abort_i) |=> (state_q != ST_SETUP));

endmodule

// File: rtl/lbist_stim.sv
module lbist_stim
  import lbist_pkg::*;
#(
  parameter int AW = 4,
  parameter int NW = 8,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_state_e      state_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic            pass_i,
  output logic            lut_we_o,
  output logic [AW-1:0]   lut_addr_o,
  output logic            lut_wdata_o,
  output logic            route_wire_o,
  output logic [NW-1:0]   wire_vec_o,
  output logic            launch_o,
  output logic            cmp_en_o,
  output logic            dly_en_o,
  output logic            dly_exp_o,
  output logic [1:0]      cls_o,
  output logic [CW-1:0]   idx_o
);

  logic in_lut;

  assign in_lut       = (state_i == ST_LWR) || (state_i == ST_LRD);
  assign lut_we_o     = (state_i == ST_LWR);
  assign lut_addr_o   = in_lut ? cnt_i[AW-1:0] : '0;
  assign lut_wdata_o  = lut_we_o & (cnt_i[0] ^ pass_i);
  assign route_wire_o = (state_i == ST_WIRE);
  assign launch_o     = (state_i == ST_DHI) || (state_i == ST_DEVAL);

  for (genvar gi = 0; gi < NW; gi++) begin : g_walk
    assign wire_vec_o[gi] = route_wire_o && (cnt_i == CW'(gi + 1));
  end

  assign cmp_en_o  = (state_i == ST_LRD) || route_wire_o;
  assign dly_en_o  = (state_i == ST_DLO) || (state_i == ST_DEVAL);
  assign dly_exp_o = (state_i == ST_DEVAL);

  always_comb begin
    case (state_i)
      ST_LRD:   begin cls_o = FC_LUT;   idx_o = cnt_i;    end
      ST_WIRE:  begin cls_o = FC_WIRE;  idx_o = cnt_i;    end
      ST_DLO:   begin cls_o = FC_DELAY; idx_o = '0;       end
      ST_DEVAL: begin cls_o = FC_DELAY; idx_o = CW'(1);   end
      default:  begin cls_o = FC_NONE;  idx_o = '0;       end
    endcase
  end

  // R5: never more than one wire driven high
  assert_walk_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wire_vec_o));

  // R3: no lookup-table write while wires are routed out
  assert_write_not_routed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we_o |-> !route_wire_o);

endmodule

// File: rtl/lbist_resp.sv
module lbist_resp
  import lbist_pkg::*;
#(
  parameter int NW = 8,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            cmp_en_i,
  input  logic [NW-1:0]   resp_a_i,
  input  logic [NW-1:0]   resp_b_i,
  input  logic            dly_en_i,
  input  logic            dly_exp_i,
  input  logic            capture_i,
  input  logic [1:0]      cls_i,
  input  logic [CW-1:0]   idx_i,
  output logic            fail_o,
  output logic [1:0]      fclass_o,
  output logic [CW-1:0]   diag_o
);

  logic          fail_q, fail_d;
  logic [1:0]    cls_q, cls_d;
  logic [CW-1:0] diag_q, diag_d;
  logic          hit;

  assign hit = (cmp_en_i && (resp_a_i != resp_b_i)) ||
               (dly_en_i && (capture_i != dly_exp_i));

  always_comb begin
    fail_d = fail_q;
    cls_d  = cls_q;
    diag_d = diag_q;
    if (clr_i) begin
      fail_d = 1'b0;
      cls_d  = FC_NONE;
      diag_d = '0;
    end else if (hit && !fail_q) begin
      fail_d = 1'b1;
      cls_d  = cls_i;
      diag_d = idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      cls_q  <= FC_NONE;
      diag_q <= '0;
    end else begin
      fail_q <= fail_d;
      cls_q  <= cls_d;
      diag_q <= diag_d;
    end
  end

  assign fail_o   = fail_q;
  assign fclass_o = cls_q;
  assign diag_o   = diag_q;

  // R7: a raised flag always carries a phase code
  assert_class_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> (cls_q != FC_NONE));

  // R9: the first record is frozen until a new session
  assert_first_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr_i) |=> (fail_q && $stable(cls_q) && $stable(diag_q)));

endmodule

// File: rtl/lbist_sequencer.sv
module lbist_sequencer
  import lbist_pkg::*;
#(
  parameter int AW = 4,
  parameter int NW = 8,
  localparam int SW = $clog2(NW + 1),
  localparam int CW = (AW > SW) ? AW : SW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic [1:0]      mode_i,
  output logic            lut_we_o,
  output logic [AW-1:0]   lut_addr_o,
  output logic            lut_wdata_o,
  output logic            route_wire_o,
  output logic [NW-1:0]   wire_vec_o,
  input  logic [NW-1:0]   resp_a_i,
  input  logic [NW-1:0]   resp_b_i,
  output logic            launch_o,
  input  logic            capture_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fail_o,
  output logic [1:0]      fclass_o,
  output logic [CW-1:0]   diag_o
);

  logic          rst_s_n;
  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          pass;
  logic          clr;
  logic          cmp_en, dly_en, dly_exp;
  logic [1:0]    cls;
  logic [CW-1:0] idx;

  lbist_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  lbist_ctrl #(.AW(AW), .NW(NW), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start_i (start_i),
    .abort_i (abort_i),
    .mode_i  (mode_i),
    .state_o (state),
    .cnt_o   (cnt),
    .pass_o  (pass),
    .clr_o   (clr),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  lbist_stim #(.AW(AW), .NW(NW), .CW(CW)) u_stim (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .state_i      (state),
    .cnt_i        (cnt),
    .pass_i       (pass),
    .lut_we_o     (lut_we_o),
    .lut_addr_o   (lut_addr_o),
    .lut_wdata_o  (lut_wdata_o),
    .route_wire_o (route_wire_o),
    .wire_vec_o   (wire_vec_o),
    .launch_o     (launch_o),
    .cmp_en_o     (cmp_en),
    .dly_en_o     (dly_en),
    .dly_exp_o    (dly_exp),
    .cls_o        (cls),
    .idx_o        (idx)
  );

  lbist_resp #(.NW(NW), .CW(CW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr_i     (clr),
    .cmp_en_i  (cmp_en),
    .resp_a_i  (resp_a_i),
    .resp_b_i  (resp_b_i),
    .dly_en_i  (dly_en),
    .dly_exp_i (dly_exp),
    .capture_i (capture_i),
    .cls_i     (cls),
    .idx_i     (idx),
    .fail_o    (fail_o),
    .fclass_o  (fclass_o),
    .diag_o    (diag_o)
  );

endmodule

// File: tb/sim_lbist_sequencer.sv
`timescale 1ns/1ps
module sim_lbist_sequencer;

  localparam int AW = 4;
  localparam int NW = 8;
  localparam int D  = 1 << AW;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic [1:0] mode = 2'b00;
  logic lut_we, lut_wdata, route, launch, capture;
  logic [AW-1:0] lut_addr;
  logic [NW-1:0] wire_vec, resp_a, resp_b;
  logic busy, done, fail;
  logic [1:0] fclass;
  logic [CW-1:0] diag;

  // fault injection state of the two unit models
  logic [D-1:0] ram_a, ram_b, sa0_a, sa1_a, sa0_b, sa1_b;
  logic br_en, st_en, slow, cap_stuck;
  int br_i, br_j, st_bit;
  logic cap1, cap2;
  logic [NW-1:0] wv_b;
  logic rd_a, rd_b;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lbist_sequencer #(.AW(AW), .NW(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort), .mode_i(mode),
    .lut_we_o(lut_we), .lut_addr_o(lut_addr), .lut_wdata_o(lut_wdata),
    .route_wire_o(route), .wire_vec_o(wire_vec), .resp_a_i(resp_a), .resp_b_i(resp_b),
    .launch_o(launch), .capture_i(capture), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fclass_o(fclass), .diag_o(diag)
  );

  always @(posedge clk) begin
    if (lut_we) begin
      ram_a[lut_addr] <= lut_wdata;
      ram_b[lut_addr] <= lut_wdata;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cap1 <= 1'b0; cap2 <= 1'b0; end
    else begin cap1 <= launch; cap2 <= cap1; end
  end
  assign capture = cap_stuck ? 1'b1 : (slow ? cap2 : cap1);

  always_comb begin
    rd_a = (ram_a[lut_addr] | sa1_a[lut_addr]) & ~sa0_a[lut_addr];
    rd_b = (ram_b[lut_addr] | sa1_b[lut_addr]) & ~sa0_b[lut_addr];
    wv_b = wire_vec;
    if (br_en) begin
      wv_b[br_i] = wire_vec[br_i] | wire_vec[br_j];
      wv_b[br_j] = wire_vec[br_i] | wire_vec[br_j];
    end
    if (st_en) wv_b[st_bit] = 1'b1;
    resp_a = route ? wire_vec : {{(NW-1){1'b0}}, rd_a};
    resp_b = route ? wv_b     : {{(NW-1){1'b0}}, rd_b};
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic no_faults();
    sa0_a = '0; sa1_a = '0; sa0_b = '0; sa1_b = '0;
    br_en = 0; st_en = 0; slow = 0; cap_stuck = 0;
    br_i = 0; br_j = 1; st_bit = 0;
  endtask

  task automatic kick(input logic [1:0] m);
    @(negedge clk); mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk("R13 busy after reset", busy, 0);
    chk("R13 done after reset", done, 0);
    chk("R13 fail after reset", fail, 0);
    chk("R13 fclass after reset", fclass, 0);
    chk("R13 stimulus after reset", {lut_we, route, launch}, 0);
  endtask

  task automatic t_clean_full();
    int n;
    no_faults();
    kick(2'b00);
    chk("R1 busy after start", busy, 1);
    wait_done(n);
    chk("R1 full run length", n, 6 + 4*D + NW);
    chk("R7 no fault flag", fail, 0);
    chk("R7 no fault class", fclass, 0);
    repeat (3) @(negedge clk);
    chk("R10 done held", done, 1);
    chk("R1 busy low after done", busy, 0);
  endtask

  task automatic t_lut_stim();
    int n;
    no_faults();
    kick(2'b01);
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk); n++;
      if (n == 1)   chk("R3 first write", {lut_we, lut_addr, lut_wdata}, {1'b1, 4'd0, 1'b0});
      if (n == 2)   chk("R3 second write", {lut_we, lut_addr, lut_wdata}, {1'b1, 4'd1, 1'b1});
      if (n == 17)  chk("R3 read no strobe", {lut_we, lut_addr, route}, {1'b0, 4'd0, 1'b0});
      if (n == 33)  chk("R3 inverse write", {lut_we, lut_addr, lut_wdata}, {1'b1, 4'd0, 1'b1});
    end
    chk("R1 lut-only length", n, 2 + 4*D);
    chk("R2 lut-only clean", fail, 0);
  endtask

  task automatic t_lut_fault(input string tag, input int expd);
    int n;
    kick(2'b01);
    wait_done(n);
    chk({tag, " flag"}, fail, 1);
    chk({tag, " class lut 01"}, fclass, 2'b01);
    chk({tag, " address"}, diag, expd);
  endtask

  task automatic t_wire_stim();
    int n;
    no_faults();
    kick(2'b10);
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk); n++;
      if (n == 1) chk("R5 zero step", {route, wire_vec}, {1'b1, 8'h00});
      if (n == 2) chk("R5 step 1", wire_vec, 8'h01);
      if (n == 4) chk("R5 step 3", wire_vec, 8'h04);
      if (n == 9) chk("R5 last step", wire_vec, 8'h80);
      if (n == 10) chk("R5 idle after sweep", {route, wire_vec}, 0);
    end
    chk("R1 wire-only length", n, 3 + NW);
    chk("R4 wires clean", fail, 0);
  endtask

  task automatic t_wire_fault(input string tag, input int expd);
    int n;
    kick(2'b10);
    wait_done(n);
    chk({tag, " class wire 10"}, fclass, 2'b10);
    chk({tag, " step"}, diag, expd);
  endtask

  task automatic t_delay_stim();
    int n;
    no_faults();
    kick(2'b11);
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk); n++;
      if (n == 1) chk("R6 launch low first", launch, 0);
      if (n == 2) chk("R6 launch high", launch, 1);
      if (n == 3) chk("R6 launch held", launch, 1);
      if (n == 4) chk("R6 launch released", launch, 0);
      if (n == 4) chk("R10 not done at eval+0", done, 0);
    end
    chk("R1 delay-only length", n, 5);
    chk("R6 good path passes", fail, 0);
  endtask

  task automatic t_delay_fault(input string tag, input int expd);
    int n;
    kick(2'b11);
    wait_done(n);
    chk({tag, " class delay 11"}, fclass, 2'b11);
    chk({tag, " code"}, diag, expd);
  endtask

  task automatic t_mode_mask();
    int n;
    no_faults(); sa1_b[4] = 1'b1;
    kick(2'b10);
    wait_done(n);
    chk("R2 lut fault hidden in wire mode", fail, 0);
    no_faults(); st_en = 1; st_bit = 1;
    kick(2'b01);
    wait_done(n);
    chk("R2 wire fault hidden in lut mode", fail, 0);
  endtask

  task automatic t_full_multi();
    int n;
    no_faults(); sa0_b[9] = 1'b1; slow = 1;
    kick(2'b00);
    wait_done(n);
    chk("R9 first phase wins", fclass, 2'b01);
    chk("R9 first address kept", diag, 9);
    repeat (5) @(negedge clk);
    chk("R7 flag sticky", fail, 1);
    no_faults();
    kick(2'b11);
    chk("R7 cleared by start", fail, 0);
    wait_done(n);
  endtask

  task automatic t_abort();
    no_faults();
    kick(2'b00);
    repeat (9) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R11 busy after abort", busy, 0);
    chk("R11 done after abort", done, 0);
    chk("R11 stimulus idle", {lut_we, route, launch}, 0);
    repeat (100) @(negedge clk);
    chk("R11 no late done", done, 0);
  endtask

  task automatic t_restart_ignored();
    int n;
    no_faults();
    kick(2'b00);
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk); n++;
      if (n == 20) begin start = 1'b1; mode = 2'b11; end
      if (n == 21) start = 1'b0;
    end
    chk("R12 run length unchanged", n, 6 + 4*D + NW);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    ram_a = '0; ram_b = '0;
    no_faults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean_full();
    t_lut_stim();
    no_faults(); sa1_b[6] = 1'b1;
    t_lut_fault("R4 R8 stuck-1 even cell", 6);
    no_faults(); sa0_a[11] = 1'b1;
    t_lut_fault("R3 R8 stuck-0 odd cell unit A", 11);
    no_faults(); sa1_b[2] = 1'b1; sa0_b[3] = 1'b1;
    t_lut_fault("R9 two cells first kept", 2);
    no_faults(); sa1_b[13] = 1'b1;
    t_lut_fault("R3 stuck-1 odd cell inverse pass", 13);
    t_wire_stim();
    no_faults(); br_en = 1; br_i = 2; br_j = 5;
    t_wire_fault("R4 R8 bridge 2-5", 3);
    no_faults(); st_en = 1; st_bit = 6;
    t_wire_fault("R8 wire stuck-1 on zero step", 0);
    t_delay_stim();
    no_faults(); slow = 1;
    t_delay_fault("R6 R8 slow path", 1);
    no_faults(); cap_stuck = 1;
    t_delay_fault("R6 R8 capture high before launch", 0);
    t_mode_mask();
    t_full_multi();
    t_abort();
    t_restart_ignored();
    report();
  end

  initial begin
    #(8 * 100000);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

endmodule